// File: doc/BRIEF.md
# Quad-Rate Burst-of-Four SRAM Device Model

This block models the device side of a quad-data-rate synchronous SRAM. Read data leaves on one port and write data arrives on another, both at once, while a single address bus serves both kinds of command. Every command moves a fixed group of four words. Each half-cycle of the device input clock is one tick of the fast clock `clk_i`. The output `k_rise_o` marks the ticks whose closing edge is a rising edge of the true input clock. All other ticks close on the complementary clock.

A read is taken on a true-clock edge. Its address goes on the bus on that tick, and the four words come out on four consecutive ticks starting two input-clock cycles later. A write select is also taken on a true-clock edge. Its address goes on the bus on the next tick, so read and write addresses share the bus on alternate edges. The four write words, with active-low byte-lane strobes, follow on the next four ticks. `q_valid_o` stands in for the echo clock and the output-driver enable. While it is low, `q_o` is zero.

Storage is an on-chip register array of `2**ADDR_W` words of `LANES*9` bits. It is cleared by reset.

Top module: `qdr_b4_sram`

## Requirements
- R1: After reset, `q_valid_o` is 0, `q_o` is 0 and every word of storage is 0. `k_rise_o` is 1 on the first tick after reset and toggles on every tick.
- R2: A read command is taken when `rd_ni` is 0 on a tick with `k_rise_o`=1, and its address is sampled on that same tick. Address bits [1:0] are ignored, so the command selects the aligned group of four words.
- R3: The words of an accepted read are stored words base+0, base+1, base+2 and base+3, in that order. They appear on `q_o` with `q_valid_o`=1 after the 4th, 5th, 6th and 7th clock edges following the command edge.
- R4: A read issued on every second true-clock edge gives an unbroken stream of valid words. After the last burst, `q_valid_o` falls to 0 and `q_o` returns to 0.
- R5: A command that arrives on the true-clock edge directly after an accepted command of the same type is ignored. For reads, no words are output for it. For writes, the group at the address on the bus in the following tick is left unchanged.
- R6: A write is taken when `wr_ni` is 0 on a tick with `k_rise_o`=1. Its address is sampled on the next tick. Its four data words are sampled on the 2nd, 3rd, 4th and 5th edges after the command edge, into base+0 through base+3.
- R7: Byte lane i, which covers data bits 9i to 9i+8, of each write word is stored only when `bw_ni[i]` is 0 on that word's tick.
- R8: Data and strobes presented on ticks outside a write burst, including while `wr_ni` is 1, do not change storage.
- R9: A read returns storage as it stood before its command edge. Words written on or after that edge by an overlapping write burst to the same group are not returned by that read.
- R10: A read and a write given on the same true-clock edge are both accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock, one tick per input-clock half-cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| k_rise_o | output | 1 | Current tick closes on a true-clock rising edge |
| rd_ni | input | 1 | Active-low read select |
| wr_ni | input | 1 | Active-low write select |
| addr_i | input | ADDR_W | Shared address bus |
| d_i | input | LANES*9 | Write data |
| bw_ni | input | LANES | Active-low byte-lane write strobes |
| q_o | output | LANES*9 | Read data, zero when not valid |
| q_valid_o | output | 1 | Read data valid (echo and drive-enable stand-in) |

## Verification
Read words become visible after the 4th to 7th edges following the command edge. The bench therefore samples `q_o` on the falling edge that follows the 4th edge, and one word per tick after that. It also checks the fall of `q_valid_o` one tick after the last word. Write results are due once the 5th edge after the command has passed, and they are observed only by later reads. For a read that overlaps a write, the bench compares against the old contents, which it saves before updating its model.

// File: rtl/qdr_b4_pkg.sv
package qdr_b4_pkg;
  localparam int BURST_LEN    = 4;
  localparam int LANE_W       = 9;
  localparam int RD_LAT_TICKS = 4;  // two input-clock cycles
  localparam int IDX_W        = $clog2(BURST_LEN);
  localparam int CNT_W        = IDX_W + 1;
endpackage

// File: rtl/qdr_b4_ctrl.sv
module qdr_b4_ctrl
  import qdr_b4_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              k_rise_o,
  output logic              rd_acc_o,
  output logic              wr_acc_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o
);
  localparam int GRP_W = ADDR_W - IDX_W;
  localparam logic [CNT_W-1:0] BL = CNT_W'(BURST_LEN);

  logic             phase_q, rd_busy_q, wr_busy_q, wr_take_q;
  logic [GRP_W-1:0] wr_base_q;
  logic [CNT_W-1:0] wr_left_q, offs;

  assign k_rise_o = ~phase_q;
  assign rd_acc_o = k_rise_o & ~rd_ni & ~rd_busy_q;
  assign wr_acc_o = k_rise_o & ~wr_ni & ~wr_busy_q;
  assign wr_en_o  = (wr_left_q != '0);
  assign offs     = BL - wr_left_q;
  assign wr_addr_o = {wr_base_q, offs[IDX_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= 1'b0;
      rd_busy_q <= 1'b0;
      wr_busy_q <= 1'b0;
      wr_take_q <= 1'b0;
      wr_base_q <= '0;
      wr_left_q <= '0;
    end else begin
      phase_q   <= ~phase_q;
      wr_take_q <= wr_acc_o;
      if (k_rise_o) begin
        rd_busy_q <= rd_acc_o;
        wr_busy_q <= wr_acc_o;
      end
      // write address rides the bus on the tick after the command
      if (wr_take_q) begin
        wr_base_q <= addr_i[ADDR_W-1:IDX_W];
        wr_left_q <= BL;
      end else if (wr_en_o) begin
        wr_left_q <= wr_left_q - 1'b1;
      end
    end
  end

  a_r1_phase_alt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    k_rise_o |=> !k_rise_o);
  a_r5_rd_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_acc_o |=> ##1 !rd_acc_o);
  a_r5_wr_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_acc_o |=> ##1 !wr_acc_o);
  a_r6_wr_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_acc_o |=> ##1 wr_en_o);
endmodule

// File: rtl/qdr_b4_store.sv
module qdr_b4_store
  import qdr_b4_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           waddr_i,
  input  logic [LANES*LANE_W-1:0]     wdata_i,
  input  logic [LANES-1:0]            wlane_ni,
  input  logic [ADDR_W-IDX_W-1:0]     rgrp_i,
  output logic [BURST_LEN*LANES*LANE_W-1:0] rgroup_o
);
  localparam int W     = LANES * LANE_W;
  localparam int DEPTH = 2 ** ADDR_W;

  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      for (int l = 0; l < LANES; l++)
        if (!wlane_ni[l]) mem_q[waddr_i][l*LANE_W +: LANE_W] <= wdata_i[l*LANE_W +: LANE_W];
    end
  end

  for (genvar g = 0; g < BURST_LEN; g++) begin : g_rd
    assign rgroup_o[g*W +: W] = mem_q[{rgrp_i, IDX_W'(g)}];
  end
endmodule

// File: rtl/qdr_b4_rd_pipe.sv
module qdr_b4_rd_pipe
  import qdr_b4_pkg::*;
#(
  parameter int W = 18
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   rd_acc_i,
  input  logic [BURST_LEN*W-1:0] group_i,
  output logic [W-1:0]           q_o,
  output logic                   q_valid_o
);
  logic [BURST_LEN*W-1:0]  pend_q, out_q;
  logic [RD_LAT_TICKS-1:0] lat_q;
  logic [CNT_W-1:0]        left_q;
  logic                    load;

  assign load      = lat_q[RD_LAT_TICKS-1];
  assign q_valid_o = (left_q != '0);
  assign q_o       = q_valid_o ? out_q[W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      out_q  <= '0;
      lat_q  <= '0;
      left_q <= '0;
    end else begin
      lat_q <= {lat_q[RD_LAT_TICKS-2:0], rd_acc_i};
      // snapshot taken at the command edge: later writes are not seen
      if (rd_acc_i) pend_q <= group_i;
      if (load) begin
        out_q  <= pend_q;
        left_q <= CNT_W'(BURST_LEN);
      end else if (q_valid_o) begin
        out_q  <= out_q >> W;
        left_q <= left_q - 1'b1;
      end
    end
  end

  a_r4_four_words: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(q_valid_o) |=> q_valid_o ##1 q_valid_o ##1 q_valid_o);
endmodule

// File: rtl/qdr_b4_sram.sv
module qdr_b4_sram
  import qdr_b4_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  output logic                    k_rise_o,
  input  logic                    rd_ni,
  input  logic                    wr_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] d_i,
  input  logic [LANES-1:0]        bw_ni,
  output logic [LANES*LANE_W-1:0] q_o,
  output logic                    q_valid_o
);
  localparam int W = LANES * LANE_W;

  logic                   rd_acc, wr_acc, wr_en;
  logic [ADDR_W-1:0]      wr_addr;
  logic [BURST_LEN*W-1:0] group;

  qdr_b4_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk_i, .rst_ni, .rd_ni, .wr_ni, .addr_i,
    .k_rise_o, .rd_acc_o(rd_acc), .wr_acc_o(wr_acc),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr)
  );

  qdr_b4_store #(.ADDR_W(ADDR_W), .LANES(LANES)) i_store (
    .clk_i, .rst_ni, .we_i(wr_en), .waddr_i(wr_addr), .wdata_i(d_i),
    .wlane_ni(bw_ni), .rgrp_i(addr_i[ADDR_W-1:IDX_W]), .rgroup_o(group)
  );

  qdr_b4_rd_pipe #(.W(W)) i_rd_pipe (
    .clk_i, .rst_ni, .rd_acc_i(rd_acc), .group_i(group),
    .q_o, .q_valid_o
  );

  a_r3_read_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_acc |=> ##4 q_valid_o);
  a_r10_both_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && wr_acc) |=> ##1 wr_en);
endmodule

// File: tb/test_qdr_b4_sram.sv
module test_qdr_b4_sram;
  localparam int AW = 6, LANES = 2, W = 18, DEPTH = 64;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [W-1:0]  seed;
    logic [7:0]    bw;   // 2 strobes per word, word i at [2i+:2]
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{6'd0,  18'h00101, 8'h00},
    '{6'd5,  18'h1a2b0, 8'h00},
    '{6'd9,  18'h23450, 8'b01_10_00_11},
    '{6'd2,  18'h3c000, 8'b10_01_10_01},
    '{6'd63, 18'h0f0f0, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_ni;
  logic rd_ni, wr_ni;
  logic [AW-1:0] addr_i;
  logic [W-1:0] d_i, q_o;
  logic [LANES-1:0] bw_ni;
  logic q_valid_o, k_rise_o;

  int errs = 0, checks = 0;
  logic [W-1:0] model [DEPTH];

  always #2 clk = ~clk;

  qdr_b4_sram #(.ADDR_W(AW), .LANES(LANES)) i_qdr_b4_sram (
    .clk_i(clk), .rst_ni, .k_rise_o, .rd_ni, .wr_ni, .addr_i,
    .d_i, .bw_ni, .q_o, .q_valid_o
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick(logic r, logic w, logic [AW-1:0] a, logic [W-1:0] dd, logic [LANES-1:0] b);
    rd_ni = r; wr_ni = w; addr_i = a; d_i = dd; bw_ni = b;
    @(negedge clk);
  endtask

  task automatic idle();
    tick(1'b1, 1'b1, '0, '0, '1);
  endtask

  task automatic align();
    if (!k_rise_o) idle();
  endtask

  function automatic logic [W-1:0] word(logic [W-1:0] seed, int i);
    return seed + W'(i) * 18'h00421;
  endfunction

  function automatic int widx(logic [AW-1:0] a, int i);
    return int'(a[AW-1:2]) * 4 + i;
  endfunction

  task automatic model_wr(logic [AW-1:0] a, logic [W-1:0] seed, logic [7:0] bw);
    for (int i = 0; i < 4; i++)
      for (int l = 0; l < LANES; l++)
        if (!bw[i*2+l]) model[widx(a, i)][l*9 +: 9] = word(seed, i)[l*9 +: 9];
  endtask

  task automatic do_write(logic [AW-1:0] a, logic [W-1:0] seed, logic [7:0] bw);
    align();
    tick(1'b1, 1'b0, '0, '0, '1);
    tick(1'b1, 1'b1, a, '0, '1);
    for (int i = 0; i < 4; i++) tick(1'b1, 1'b1, '0, word(seed, i), bw[i*2 +: 2]);
    model_wr(a, seed, bw);
  endtask

  task automatic do_read(logic [AW-1:0] a, string req);
    align();
    tick(1'b0, 1'b1, a, '0, '1);
    repeat (4) idle();
    for (int i = 0; i < 4; i++) begin
      chk({req, " valid"}, 32'(q_valid_o), 32'd1);
      chk({req, " data"}, 32'(q_o), 32'(model[widx(a, i)]));
      idle();
    end
    chk({req, " deselect valid"}, 32'(q_valid_o), 32'd0);
    chk({req, " deselect q"}, 32'(q_o), 32'd0);
  endtask

  initial begin
    #800000;
    errs++; checks++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] old [4];
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    rst_ni = 1'b0; rd_ni = 1'b1; wr_ni = 1'b1; addr_i = '0; d_i = '0; bw_ni = '1;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state and phase
    chk("R1 valid", 32'(q_valid_o), 32'd0);
    chk("R1 q", 32'(q_o), 32'd0);
    chk("R1 k_rise first", 32'(k_rise_o), 32'd1);
    idle();
    chk("R1 k_rise toggles", 32'(k_rise_o), 32'd0);
    idle();
    do_read(6'd12, "R1 cleared storage");

    // vector table: R2 R3 R6 R7
    foreach (VECS[v]) begin
      do_write(VECS[v].addr, VECS[v].seed, VECS[v].bw);
      do_read(VECS[v].addr ^ 6'd3, "R3 R6 R7 table");
    end

    // R4 back-to-back reads at every second K rise
    align();
    tick(1'b0, 1'b1, 6'd0, '0, '1);
    repeat (3) idle();
    tick(1'b0, 1'b1, 6'd4, '0, '1);
    for (int i = 0; i < 8; i++) begin
      chk("R4 stream valid", 32'(q_valid_o), 32'd1);
      chk("R4 stream data", 32'(q_o), 32'(model[i]));
      idle();
    end
    chk("R4 deselect valid", 32'(q_valid_o), 32'd0);
    chk("R4 deselect q", 32'(q_o), 32'd0);

    // R5 read ignored on the K rise after an accepted read
    align();
    tick(1'b0, 1'b1, 6'd8, '0, '1);
    idle();
    tick(1'b0, 1'b1, 6'd4, '0, '1);
    idle(); idle();
    for (int i = 0; i < 4; i++) begin
      chk("R5 read data", 32'(q_o), 32'(model[8 + i]));
      idle();
    end
    chk("R5 extra read ignored", 32'(q_valid_o), 32'd0);

    // R5 write ignored: second select plus address 20 on next tick
    align();
    tick(1'b1, 1'b0, '0, '0, '1);
    tick(1'b1, 1'b1, 6'd16, '0, '1);
    tick(1'b1, 1'b0, '0, word(18'h2aaaa, 0), 2'b00);
    tick(1'b1, 1'b1, 6'd20, word(18'h2aaaa, 1), 2'b00);
    tick(1'b1, 1'b1, '0, word(18'h2aaaa, 2), 2'b00);
    tick(1'b1, 1'b1, '0, word(18'h2aaaa, 3), 2'b00);
    model_wr(6'd16, 18'h2aaaa, 8'h00);
    repeat (4) idle();
    do_read(6'd16, "R5 first write stored");
    do_read(6'd20, "R5 second write ignored");

    // R8 data with write select idle
    repeat (8) tick(1'b1, 1'b1, 6'd0, 18'h3ffff, 2'b00);
    do_read(6'd0, "R8 idle data ignored");
    do_read(6'd16, "R8 idle data ignored");

    // R10 read and write on the same K rise; R9 read sees old data
    for (int i = 0; i < 4; i++) old[i] = model[24 + i];
    align();
    tick(1'b0, 1'b0, 6'd24, '0, '1);
    tick(1'b1, 1'b1, 6'd24, '0, '1);
    tick(1'b1, 1'b1, '0, word(18'h15555, 0), 2'b00);
    tick(1'b1, 1'b1, '0, word(18'h15555, 1), 2'b00);
    tick(1'b1, 1'b1, '0, word(18'h15555, 2), 2'b00);
    chk("R10 read taken", 32'(q_valid_o), 32'd1);
    chk("R10 old data", 32'(q_o), 32'(old[0]));
    tick(1'b1, 1'b1, '0, word(18'h15555, 3), 2'b00);
    for (int i = 1; i < 4; i++) begin
      chk("R10 old data", 32'(q_o), 32'(old[i]));
      idle();
    end
    model_wr(6'd24, 18'h15555, 8'h00);
    do_read(6'd24, "R10 write taken");

    // R9 read issued while a write to the same group is running
    for (int i = 0; i < 4; i++) old[i] = model[28 + i];
    align();
    tick(1'b1, 1'b0, '0, '0, '1);
    tick(1'b1, 1'b1, 6'd28, '0, '1);
    tick(1'b0, 1'b1, 6'd28, word(18'h0beef, 0), 2'b00);
    tick(1'b1, 1'b1, '0, word(18'h0beef, 1), 2'b00);
    tick(1'b1, 1'b1, '0, word(18'h0beef, 2), 2'b00);
    tick(1'b1, 1'b1, '0, word(18'h0beef, 3), 2'b00);
    idle();
    for (int i = 0; i < 4; i++) begin
      chk("R9 overlap old data", 32'(q_o), 32'(old[i]));
      idle();
    end
    model_wr(6'd28, 18'h0beef, 8'h00);
    do_read(6'd28, "R9 new data after");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule